// File: doc/BRIEF.md
# Floating-Point Support-Code Trap Decider

This block sits beside a single-precision floating-point pipeline and decides, for each data-processing operation offered to it, whether the hardware may complete the operation or whether it has to be handed to software support code. It does no arithmetic. It classifies every participating operand as zero, subnormal, normal, infinity or NaN. From the operand exponents it makes a conservative estimate of whether the result could overflow or underflow. It then weighs those findings against a small mode register: a flush-to-zero switch, a default-NaN switch and three exception-trap enables.

Software programs the mode register through a 32-bit write port. Operations are then presented with an opcode, up to three operands and a valid strobe. One cycle later the block reports a valid flag, a bounce flag and a 3-bit reason code. When flush-to-zero and default-NaN are both on and every trap enable is off, the block never bounces. This gives a fast mode with a fixed run time.

Top module: `fp_trap_decider`

## Requirements
- R1: After reset, res_valid, res_bounce and res_reason are 0 and every mode bit is clear, so a following operation with a subnormal input bounces with reason 2.
- R2: res_valid is 1 exactly one cycle after a cycle with op_valid high. In a cycle after op_valid low, res_valid, res_bounce and res_reason are all 0.
- R3: A write with cfg_wr_en high stores flush-to-zero from data bit 24, default-NaN from bit 25, inexact trap from bit 12, overflow trap from bit 10 and invalid trap from bit 8. All other data bits are ignored. An operation presented in the same cycle as a write is judged with the settings from before that write.
- R4: op_code 0 is add, 1 is subtract, 2 is multiply and 3 is multiply-accumulate (op_c + op_a*op_b). op_c takes part only for code 3. Classes follow IEEE single-precision fields: exponent 0 with mantissa 0 is zero, exponent 0 with mantissa non-zero is subnormal, exponent 255 with mantissa 0 is infinity, exponent 255 with mantissa non-zero is NaN, and anything else is normal.
- R5: An operation with a participating NaN operand bounces with reason 1 when default-NaN is clear.
- R6: An operation with a participating subnormal operand bounces with reason 2 when flush-to-zero is clear.
- R7: Every operation bounces with reason 3 when the inexact trap is set, unless a higher-priority cause applies.
- R8: The exponent estimate uses unbiased exponents of normal participants only. Add and subtract use the larger exponent plus one. Multiply uses the sum of the two exponents and needs both operands normal. Multiply-accumulate uses the larger of the product sum (when both factors are normal) and the addend exponent, plus one. There is no estimate if no term is present or if any participant is infinity or NaN. An estimate of 127 or more bounces with reason 4 when the overflow trap is set.
- R9: An estimate of -126 or less bounces with reason 5 when flush-to-zero is clear.
- R10: A multiply-accumulate whose normal factors have an exponent sum of 127 or more, with an infinite addend whose sign differs from the product sign, bounces with reason 6 when the invalid trap is set.
- R11: When several causes apply, only the highest is reported, in the order NaN (1), subnormal (2), inexact (3), overflow (4), underflow (5), invalid (6). res_bounce is 1 exactly when res_reason is non-zero.
- R12: With flush-to-zero and default-NaN set and all three trap enables clear, no operation bounces.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Mode register write strobe |
| cfg_wr_data | input | 32 | Mode register write data |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 2 | Operation kind |
| op_a | input | 32 | First operand (multiplicand for multiply forms) |
| op_b | input | 32 | Second operand |
| op_c | input | 32 | Addend for multiply-accumulate |
| res_valid | output | 1 | Decision valid, one cycle after op_valid |
| res_bounce | output | 1 | Operation must go to support code |
| res_reason | output | 3 | Highest-priority bounce cause, 0 for none |

## Verification
A corrupted mode bit shows up at the ports on the very next operation that depends on it. For example, a lost flush-to-zero bit makes the next subnormal operand return reason 2 instead of no bounce. A fault in a classifier or in the exponent estimate changes the reason code one cycle after the offending operation. A fault in the priority chain shows up only when two causes coincide. The stimulus therefore mixes extreme exponents, specials and random mode settings so that overlapping causes occur often. The decision has no memory beyond the mode register, so every fault is visible within one cycle of the operation that triggers it.

// File: rtl/fptd_pkg.sv
// Shared types for the floating-point trap decider.
// Assumes single-precision style operands; widths come from module parameters.
package fptd_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO = 3'd0,
        CLS_SUB  = 3'd1,
        CLS_NORM = 3'd2,
        CLS_INF  = 3'd3,
        CLS_NAN  = 3'd4
    } fclass_e;

    typedef enum logic [1:0] {
        OP_ADD = 2'd0,
        OP_SUB = 2'd1,
        OP_MUL = 2'd2,
        OP_MAC = 2'd3
    } fop_e;

    typedef enum logic [2:0] {
        RSN_NONE    = 3'd0,
        RSN_NAN     = 3'd1,
        RSN_SUBN    = 3'd2,
        RSN_INEXACT = 3'd3,
        RSN_OVF     = 3'd4,
        RSN_UNF     = 3'd5,
        RSN_INVALID = 3'd6
    } reason_e;

    typedef struct packed {
        logic fz;   // flush-to-zero
        logic dn;   // default NaN
        logic ixe;  // inexact trap enable
        logic ofe;  // overflow trap enable
        logic ioe;  // invalid trap enable
    } mode_t;

endpackage

// File: rtl/fptd_mode_reg.sv
// Mode register: keeps only the five mode/trap bits picked out of a wide write.
// Assumes a write is seen by operations from the following cycle onward.
module fptd_mode_reg
    import fptd_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int FZ_POS  = 24,
    parameter int DN_POS  = 25,
    parameter int IXE_POS = 12,
    parameter int OFE_POS = 10,
    parameter int IOE_POS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output mode_t            mode_q
);

    logic unused_wr_bits;
    assign unused_wr_bits = ^wr_data;

    // Capture the selected bits on a write; clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (wr_en) begin
            mode_q.fz  <= wr_data[FZ_POS];
            mode_q.dn  <= wr_data[DN_POS];
            mode_q.ixe <= wr_data[IXE_POS];
            mode_q.ofe <= wr_data[OFE_POS];
            mode_q.ioe <= wr_data[IOE_POS];
        end
    end

endmodule

// File: rtl/fptd_classify.sv
// Operand classifier: splits one word into class, sign and unbiased exponent.
// Assumes IEEE-style layout {sign, exponent, mantissa}; the exponent output
// is meaningful only for normal operands.
module fptd_classify
    import fptd_pkg::*;
#(
    parameter int EXP_W = 8,
    parameter int MAN_W = 23,
    localparam int DW   = 1 + EXP_W + MAN_W,
    localparam int SW   = EXP_W + 2
) (
    input  logic [DW-1:0]        word,
    output fclass_e              cls,
    output logic                 sgn,
    output logic signed [SW-1:0] uexp
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [SW-1:0] BIAS_S = SW'(BIAS);

    logic [EXP_W-1:0] exp_f;
    logic [MAN_W-1:0] man_f;

    assign sgn   = word[DW-1];
    assign exp_f = word[DW-2 -: EXP_W];
    assign man_f = word[MAN_W-1:0];
    assign uexp  = $signed({2'b00, exp_f}) - BIAS_S;

    // Decide the class from the exponent and mantissa fields.
    always_comb begin
        if (exp_f == '0)
            cls = (man_f == '0) ? CLS_ZERO : CLS_SUB;
        else if (exp_f == '1)
            cls = (man_f == '0) ? CLS_INF : CLS_NAN;
        else
            cls = CLS_NORM;
    end

endmodule

// File: rtl/fptd_range_est.sv
// Exponent range estimator: flags a possible overflow, a possible underflow
// and the product-overflow-meets-opposite-infinity case of multiply-accumulate.
// Assumes operands are already classified; only normal operands contribute.
module fptd_range_est
    import fptd_pkg::*;
#(
    parameter int EXP_W = 8,
    localparam int SW   = EXP_W + 2
) (
    input  fop_e                 op,
    input  fclass_e              cls_a,
    input  fclass_e              cls_b,
    input  fclass_e              cls_c,
    input  logic                 sgn_a,
    input  logic                 sgn_b,
    input  logic                 sgn_c,
    input  logic signed [SW-1:0] ue_a,
    input  logic signed [SW-1:0] ue_b,
    input  logic signed [SW-1:0] ue_c,
    output logic                 may_ovf,
    output logic                 may_unf,
    output logic                 may_inv
);

    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam logic signed [SW-1:0] OVF_LIM = SW'(BIAS);
    localparam logic signed [SW-1:0] UNF_LIM = SW'(-(BIAS - 1));
    localparam logic signed [SW-1:0] ONE_S   = SW'(1);

    logic                 n_a, n_b, n_c, prod_ok, special;
    logic signed [SW-1:0] prod_e, est;
    logic                 have;

    assign n_a     = (cls_a == CLS_NORM);
    assign n_b     = (cls_b == CLS_NORM);
    assign n_c     = (cls_c == CLS_NORM);
    assign prod_ok = n_a && n_b;
    assign prod_e  = ue_a + ue_b;

    // Any infinite or NaN participant suppresses the estimate.
    always_comb begin
        special = (cls_a == CLS_INF) || (cls_a == CLS_NAN) ||
                  (cls_b == CLS_INF) || (cls_b == CLS_NAN);
        if (op == OP_MAC)
            special = special || (cls_c == CLS_INF) || (cls_c == CLS_NAN);
    end

    // Build the result exponent estimate per operation kind.
    always_comb begin
        have = 1'b0;
        est  = '0;
        unique case (op)
            OP_ADD, OP_SUB: begin
                have = n_a || n_b;
                if (n_a && (!n_b || ue_a >= ue_b)) est = ue_a + ONE_S;
                else                                est = ue_b + ONE_S;
            end
            OP_MUL: begin
                have = prod_ok;
                est  = prod_e;
            end
            OP_MAC: begin
                have = prod_ok || n_c;
                if (prod_ok && (!n_c || prod_e >= ue_c)) est = prod_e + ONE_S;
                else                                      est = ue_c + ONE_S;
            end
            default: begin
                have = 1'b0;
                est  = '0;
            end
        endcase
    end

    // Compare the estimate against the representable range limits.
    always_comb begin
        may_ovf = have && !special && (est >= OVF_LIM);
        may_unf = have && !special && (est <= UNF_LIM);
    end

    // Large product meeting an infinity of the opposite sign.
    always_comb begin
        may_inv = (op == OP_MAC) && prod_ok && (prod_e >= OVF_LIM) &&
                  (cls_c == CLS_INF) && (sgn_c != (sgn_a ^ sgn_b));
    end

endmodule

// File: rtl/fp_trap_decider.sv
// Top: classifies operands, estimates range, applies mode bits and a fixed
// cause priority, and registers the decision one cycle after op_valid.
// Assumes at most one operation per cycle; op_c is used only by multiply-accumulate.
module fp_trap_decider
    import fptd_pkg::*;
#(
    parameter int CFG_W   = 32,
    parameter int EXP_W   = 8,
    parameter int MAN_W   = 23,
    parameter int FZ_POS  = 24,
    parameter int DN_POS  = 25,
    parameter int IXE_POS = 12,
    parameter int OFE_POS = 10,
    parameter int IOE_POS = 8,
    localparam int DW     = 1 + EXP_W + MAN_W,
    localparam int SW     = EXP_W + 2,
    localparam int NOPND  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr_en,
    input  logic [CFG_W-1:0] cfg_wr_data,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [DW-1:0]    op_a,
    input  logic [DW-1:0]    op_b,
    input  logic [DW-1:0]    op_c,
    output logic             res_valid,
    output logic             res_bounce,
    output logic [2:0]       res_reason
);

    mode_t                mode_q;
    fop_e                 op;
    logic [DW-1:0]        opnd [NOPND];
    fclass_e              cls  [NOPND];
    logic                 sgn  [NOPND];
    logic signed [SW-1:0] uexp [NOPND];
    logic [NOPND-1:0]     live;
    logic                 any_nan, any_sub;
    logic                 may_ovf, may_unf, may_inv;
    reason_e              rsn;

    assign op      = fop_e'(op_code);
    assign opnd[0] = op_a;
    assign opnd[1] = op_b;
    assign opnd[2] = op_c;
    assign live    = {op == OP_MAC, 1'b1, 1'b1};

    fptd_mode_reg #(
        .CFG_W(CFG_W), .FZ_POS(FZ_POS), .DN_POS(DN_POS),
        .IXE_POS(IXE_POS), .OFE_POS(OFE_POS), .IOE_POS(IOE_POS)
    ) u_mode (
        .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en),
        .wr_data(cfg_wr_data), .mode_q(mode_q)
    );

    for (genvar i = 0; i < NOPND; i++) begin : g_cls
        fptd_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
            .word(opnd[i]), .cls(cls[i]), .sgn(sgn[i]), .uexp(uexp[i])
        );
    end

    fptd_range_est #(.EXP_W(EXP_W)) u_est (
        .op(op),
        .cls_a(cls[0]), .cls_b(cls[1]), .cls_c(cls[2]),
        .sgn_a(sgn[0]), .sgn_b(sgn[1]), .sgn_c(sgn[2]),
        .ue_a(uexp[0]), .ue_b(uexp[1]), .ue_c(uexp[2]),
        .may_ovf(may_ovf), .may_unf(may_unf), .may_inv(may_inv)
    );

    // Gather NaN and subnormal presence over participating operands.
    always_comb begin
        any_nan = 1'b0;
        any_sub = 1'b0;
        for (int i = 0; i < NOPND; i++) begin
            any_nan = any_nan || (live[i] && cls[i] == CLS_NAN);
            any_sub = any_sub || (live[i] && cls[i] == CLS_SUB);
        end
    end

    // Pick the highest-priority cause that the mode bits leave active.
    always_comb begin
        if (any_nan && !mode_q.dn)       rsn = RSN_NAN;
        else if (any_sub && !mode_q.fz)  rsn = RSN_SUBN;
        else if (mode_q.ixe)             rsn = RSN_INEXACT;
        else if (may_ovf && mode_q.ofe)  rsn = RSN_OVF;
        else if (may_unf && !mode_q.fz)  rsn = RSN_UNF;
        else if (may_inv && mode_q.ioe)  rsn = RSN_INVALID;
        else                             rsn = RSN_NONE;
    end

    // Register the decision; idle cycles report nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_bounce <= 1'b0;
            res_reason <= 3'd0;
        end else begin
            res_valid  <= op_valid;
            res_bounce <= op_valid && (rsn != RSN_NONE);
            res_reason <= op_valid ? rsn : RSN_NONE;
        end
    end

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> res_valid); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !res_bounce && res_reason == 3'd0)); // R2
    AST_INEXACT_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && mode_q.ixe) |=> res_bounce); // R7
    AST_FAST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && mode_q.fz && mode_q.dn && !mode_q.ixe && !mode_q.ofe && !mode_q.ioe)
        |=> !res_bounce); // R12
    AST_RANGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(may_ovf && may_unf)); // R8
    AST_REASON_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        res_reason <= 3'd6 && (res_bounce == (res_reason != 3'd0))); // R11
    AST_NAN_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && any_nan && !mode_q.dn) |=> (res_reason == 3'd1)); // R5

endmodule

// File: tb/tb_fp_trap_decider.sv
`timescale 1ns/1ps
module tb_fp_trap_decider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [31:0] cfg_wr_data = '0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = '0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0;
    logic        res_valid, res_bounce;
    logic [2:0]  res_reason;

    int total = 0;
    int bad = 0;
    logic [4:0] cur_mode = '0;   // {fz, dn, ixe, ofe, ioe}

    localparam logic [31:0] M_FZ = 32'h0100_0000, M_DN = 32'h0200_0000,
                            M_IX = 32'h0000_1000, M_OF = 32'h0000_0400,
                            M_IO = 32'h0000_0100;
    localparam logic [31:0] ONE = 32'h3F80_0000, QNAN = 32'h7FC0_0000,
                            SUBN = 32'h0000_0001, PINF = 32'h7F80_0000,
                            NINF = 32'hFF80_0000, BIG = 32'h6400_0000,
                            SMALL = 32'h0A00_0000, MAXE = 32'h7F00_0000;

    always #4 clk = ~clk;

    fp_trap_decider dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b), .op_c(op_c),
        .res_valid(res_valid), .res_bounce(res_bounce), .res_reason(res_reason)
    );

    function automatic int cls_of(input logic [31:0] w);
        if (w[30:23] == 8'd0)   return (w[22:0] == 0) ? 0 : 1;
        if (w[30:23] == 8'hFF)  return (w[22:0] == 0) ? 3 : 4;
        return 2;
    endfunction

    function automatic int ex_of(input logic [31:0] w);
        return int'(w[30:23]) - 127;
    endfunction

    function automatic logic [4:0] mode_of(input logic [31:0] d);
        return {d[24], d[25], d[12], d[10], d[8]};
    endfunction

    // Expected {bounce, reason} from the requirements.
    function automatic logic [3:0] model(input logic [4:0] m, input int op,
                                         input logic [31:0] a, b, c);
        int ca, cb, cc, ea, eb, ec, est, rs;
        bit nan, sub, spec, have, ovf, unf, inv;
        ca = cls_of(a); cb = cls_of(b); cc = cls_of(c);
        ea = ex_of(a); eb = ex_of(b); ec = ex_of(c);
        nan  = (ca == 4) || (cb == 4) || (op == 3 && cc == 4);
        sub  = (ca == 1) || (cb == 1) || (op == 3 && cc == 1);
        spec = (ca >= 3) || (cb >= 3) || (op == 3 && cc >= 3);
        have = 0; est = 0;
        if (op < 2) begin
            if (ca == 2) begin have = 1; est = ea + 1; end
            if (cb == 2 && (!have || eb + 1 > est)) begin have = 1; est = eb + 1; end
        end else if (op == 2) begin
            have = (ca == 2 && cb == 2); est = ea + eb;
        end else begin
            if (ca == 2 && cb == 2) begin have = 1; est = ea + eb; end
            if (cc == 2 && (!have || ec > est)) begin have = 1; est = ec; end
            est = est + 1;
        end
        ovf = have && !spec && est >= 127;
        unf = have && !spec && est <= -126;
        inv = (op == 3) && ca == 2 && cb == 2 && (ea + eb >= 127) && cc == 3 &&
              (c[31] != (a[31] ^ b[31]));
        if (nan && !m[3])      rs = 1;
        else if (sub && !m[4]) rs = 2;
        else if (m[2])         rs = 3;
        else if (ovf && m[1])  rs = 4;
        else if (unf && !m[4]) rs = 5;
        else if (inv && m[0])  rs = 6;
        else                   rs = 0;
        return {rs != 0, 3'(rs)};
    endfunction

    task automatic check(input string rq, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, got, exp);
        end
    endtask

    task automatic write_mode(input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        cur_mode = mode_of(d);
    endtask

    // Present one operation, then sample the registered result one cycle later.
    task automatic run_op(input string rq, input int op, input logic [31:0] a, b, c);
        logic [3:0] e;
        @(negedge clk);
        op_valid = 1'b1; op_code = 2'(op); op_a = a; op_b = b; op_c = c;
        e = model(cur_mode, op, a, b, c);
        @(negedge clk);
        op_valid = 1'b0;
        check(rq, {res_valid, res_bounce, res_reason}, {1'b1, e});
    endtask

    function automatic logic [31:0] rand_opnd();
        int k;
        logic s;
        k = int'($urandom % 10); s = 1'($urandom);
        case (k)
            0: return {s, 31'd0};
            1: return {s, 8'd0, 23'($urandom % 8388607 + 1)};
            2: return {s, 8'hFF, 23'd0};
            3: return {s, 8'hFF, 23'($urandom % 8388607 + 1)};
            4, 5: return {s, 8'(190 + $urandom % 65), 23'($urandom)};
            6, 7: return {s, 8'(1 + $urandom % 64), 23'($urandom)};
            default: return {s, 8'(1 + $urandom % 254), 23'($urandom)};
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset outputs", {res_valid, res_bounce, res_reason}, 5'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {res_valid, res_bounce, res_reason}, 5'd0);
        run_op("R1 cleared mode subnormal", 0, SUBN, ONE, ONE);
        check("R1 reason value", {29'd0, res_reason}, 32'd2);
        @(negedge clk);
        check("R2 idle after op", {res_valid, res_bounce, res_reason}, 5'd0);

        // R3: same-cycle write uses the old settings
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_data = M_FZ;
        op_valid = 1'b1; op_code = 2'd0; op_a = SUBN; op_b = ONE; op_c = ONE;
        @(negedge clk);
        cfg_wr_en = 1'b0; op_valid = 1'b0; cur_mode = mode_of(M_FZ);
        check("R3 same-cycle write uses old mode", {res_bounce, res_reason}, {1'b1, 3'd2});
        run_op("R3 new mode applies", 0, SUBN, ONE, ONE);
        check("R3 flushed subnormal no bounce", {31'd0, res_bounce}, 32'd0);
        write_mode(32'hFCFF_EAFF & ~(M_FZ | M_DN | M_IX | M_OF | M_IO));
        run_op("R3 unrelated bits ignored", 2, SUBN, ONE, ONE);
        check("R3 unrelated bits leave fz clear", {29'd0, res_reason}, 32'd2);

        // R4 / R5: op_c only for mac
        write_mode(M_FZ);
        run_op("R4 add ignores op_c NaN", 0, ONE, ONE, QNAN);
        check("R4 add op_c ignored", {31'd0, res_bounce}, 32'd0);
        run_op("R5 mac NaN addend", 3, ONE, ONE, QNAN);
        check("R5 reason", {29'd0, res_reason}, 32'd1);
        write_mode(M_FZ | M_DN);
        run_op("R5 default NaN suppresses", 1, QNAN, ONE, ONE);
        run_op("R6 subnormal flushed", 3, ONE, ONE, SUBN);
        write_mode(M_DN);
        run_op("R6 subnormal mac addend", 3, ONE, ONE, SUBN);
        run_op("R7 idle mode no bounce", 0, ONE, ONE, ONE);
        write_mode(M_FZ | M_DN | M_IX);
        run_op("R7 inexact trap", 2, ONE, ONE, ONE);
        check("R7 reason", {29'd0, res_reason}, 32'd3);

        // R8 overflow estimate
        write_mode(M_FZ | M_DN | M_OF);
        run_op("R8 mul overflow", 2, BIG, BIG, ONE);
        check("R8 reason", {29'd0, res_reason}, 32'd4);
        run_op("R8 add below limit", 0, BIG, BIG, ONE);
        run_op("R8 add at max exponent", 0, MAXE, ONE, ONE);
        run_op("R8 mul with zero no estimate", 2, BIG, 32'd0, ONE);
        run_op("R8 mul with infinity no estimate", 2, BIG, PINF, ONE);
        run_op("R8 mac large product", 3, BIG, BIG, ONE);

        // R9 underflow estimate
        write_mode(M_DN);
        run_op("R9 mul underflow", 2, SMALL, SMALL, ONE);
        check("R9 reason", {29'd0, res_reason}, 32'd5);
        run_op("R9 mac small product and zero addend", 3, SMALL, SMALL, 32'd0);
        write_mode(M_DN | M_FZ);
        run_op("R9 flush masks underflow", 2, SMALL, SMALL, ONE);

        // R10 invalid combination
        write_mode(M_FZ | M_DN | M_IO);
        run_op("R10 large product minus infinity", 3, BIG, BIG, NINF);
        check("R10 reason", {29'd0, res_reason}, 32'd6);
        run_op("R10 same-sign infinity", 3, BIG, BIG, PINF);
        run_op("R10 negative product plus infinity", 3, {1'b1, BIG[30:0]}, BIG, PINF);

        // R11 priority
        write_mode(32'd0);
        run_op("R11 NaN over subnormal", 0, QNAN, SUBN, ONE);
        write_mode(M_IX | M_OF);
        run_op("R11 subnormal over inexact", 2, SUBN, BIG, ONE);
        write_mode(M_FZ | M_IX | M_OF);
        run_op("R11 inexact over overflow", 2, BIG, BIG, ONE);
        write_mode(M_DN | M_OF | M_IO);
        run_op("R11 overflow over underflow", 3, SMALL, SMALL, MAXE);

        // R12 fast mode, random operands
        write_mode(M_FZ | M_DN | 32'h00C0_0003);
        for (int i = 0; i < 300; i++) begin
            run_op("R12 fast mode", int'($urandom % 4), rand_opnd(), rand_opnd(), rand_opnd());
            check("R12 fast mode never bounces", {31'd0, res_bounce}, 32'd0);
        end

        // Random modes and operands against the model
        for (int i = 0; i < 2500; i++) begin
            if (i % 5 == 0)
                write_mode({6'd0, 2'($urandom), 11'd0, 1'($urandom % 4 == 0), 1'b0,
                            1'($urandom), 1'b0, 1'($urandom), 8'($urandom)});
            run_op("R11 random mix", int'($urandom % 4), rand_opnd(), rand_opnd(), rand_opnd());
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule